// File: doc/BRIEF.md
# Shift-Right-Then-XOR Memory Instruction Unit

This block sequences one read-modify-write instruction of an 8-bit processor that has a 16-bit address bus. When started with an opcode, the program counter and the A, X and Y register values, it fetches its operand bytes. It forms the effective address in one of seven addressing modes and reads the target byte. It writes that byte back unchanged, then writes it again shifted right by one place. Finally it folds the shifted byte into the accumulator with XOR and reports the new accumulator together with carry, negative and zero flags.

The unit drives a single-cycle memory bus. In every clock it presents an address. The memory returns read data for that address within the same cycle, and a write is committed at the closing clock edge. The start cycle is bus cycle 1, which is the opcode fetch at the program counter. The unit ignores the data read in that cycle, because the opcode arrives on its own port. Each mode uses a fixed number of bus cycles, and the result is reported with a one-cycle `done` pulse in the cycle that follows the last bus cycle. An opcode outside the supported set produces a one-cycle error pulse and no bus activity beyond the fetch.

Top module: `rmw_shx_unit`

## Requirements
- R1: The supported opcodes are 0x47 zero page, 0x57 zero page,X, 0x4F absolute, 0x5F absolute,X, 0x5B absolute,Y, 0x43 (zp,X) and 0x53 (zp),Y. Any other opcode sampled with `start` in idle raises `bad_op` for exactly the next cycle, produces no `done` and no bus write, and leaves the unit idle.
- R2: The start cycle is bus cycle 1, and the instruction uses a fixed number of bus cycles: 5 for zero page, 6 for zero page,X and absolute, 7 for absolute,X and absolute,Y, and 8 for both indirect modes. `done` is high for one cycle, in the cycle after the last bus cycle.
- R3: The addresses on the bus follow a fixed sequence. The opcode fetch is at PC, the first operand byte is at PC+1, and for the absolute forms the high address byte is at PC+2. All 16-bit values are little-endian.
- R4: For zero page,X the effective address is (operand+X) mod 256. For (zp,X) the pointer bytes are read at (operand+X) mod 256 and at (operand+X+1) mod 256. For (zp),Y the pointer high byte is read at (operand+1) mod 256. Address bits 15..8 are zero in all these cases, and zero page,X and (zp,X) first make a dummy read at the unindexed zero-page operand.
- R5: For absolute,X, absolute,Y and (zp),Y, the unit makes a dummy read at {base high, (base low + index) mod 256}. It then reads at the full 16-bit sum, so the cycle count is the same whether or not a page is crossed.
- R6: The two final bus cycles are writes to the effective address. The first writes the byte just read, unchanged.
- R7: The second write stores the original byte shifted right by one place, with 0 entering bit 7, and this is the final memory content.
- R8: The new accumulator is the A value latched at start XOR the shifted byte. Carry equals bit 0 of the original memory byte.
- R9: Negative equals bit 7 of the new accumulator, and zero is set exactly when the new accumulator is 0x00.
- R10: `start` is ignored while an instruction is in progress, whatever the opcode presented with it.
- R11: During and after reset, `done`, `bad_op` and `bus_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction; its cycle is the opcode fetch |
| opcode | input | 8 | Opcode of the instruction, valid with start |
| pc | input | 16 | Address of the opcode byte, valid with start |
| a_in | input | 8 | Accumulator value, latched at start |
| x_in | input | 8 | X index value, latched at start |
| y_in | input | 8 | Y index value, latched at start |
| bus_addr | output | 16 | Memory address for the current cycle |
| bus_we | output | 1 | Write enable for the current cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data for bus_addr, valid in the same cycle |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 8 | New accumulator value |
| c_out | output | 1 | Carry flag result |
| n_out | output | 1 | Negative flag result |
| z_out | output | 1 | Zero flag result |
| bad_op | output | 1 | One-cycle unsupported-opcode pulse |

## Verification
Assertions check on every cycle that the first write repeats the byte read just before it, at the same address. They also check that the second write is that byte shifted right at the same address, that the accumulator and carry reported at `done` come from the latched A and the written bytes, that zero-page steps never leave page zero, and that `done` and `bad_op` behave as single pulses. Only the bench scenarios can show the exact per-mode address sequence and cycle count. The same holds for the zero-page wrap of pointers and indexed operands, the dummy read before a page-crossing correction, the final memory contents, and the rejection of opcodes and of a `start` pulse raised in mid-instruction.

// File: rtl/rmw_shx_pkg.sv
package rmw_shx_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_ZP   = 8'h47;
   localparam logic [OPC_W-1:0] OPC_ZPX  = 8'h57;
   localparam logic [OPC_W-1:0] OPC_ABS  = 8'h4F;
   localparam logic [OPC_W-1:0] OPC_ABSX = 8'h5F;
   localparam logic [OPC_W-1:0] OPC_ABSY = 8'h5B;
   localparam logic [OPC_W-1:0] OPC_IZX  = 8'h43;
   localparam logic [OPC_W-1:0] OPC_IZY  = 8'h53;

   typedef enum logic [2:0] {
      AM_ZP, AM_ZPX, AM_ABS, AM_ABSX, AM_ABSY, AM_IZX, AM_IZY
   } amode_t;

   typedef enum logic [3:0] {
      ST_IDLE, ST_OPR1, ST_OPR2, ST_ZDUM, ST_PLO, ST_PHI,
      ST_FIX, ST_READ, ST_WOLD, ST_WNEW
   } step_t;

endpackage

// File: rtl/rmw_shx_decode.sv
module rmw_shx_decode
   import rmw_shx_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output amode_t           mode,
   output logic             legal
);

   always_comb begin
      legal = 1'b1;
      mode  = AM_ZP;
      case (opcode)
         OPC_ZP:   mode = AM_ZP;
         OPC_ZPX:  mode = AM_ZPX;
         OPC_ABS:  mode = AM_ABS;
         OPC_ABSX: mode = AM_ABSX;
         OPC_ABSY: mode = AM_ABSY;
         OPC_IZX:  mode = AM_IZX;
         OPC_IZY:  mode = AM_IZY;
         default:  legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/rmw_shx_alu.sv
module rmw_shx_alu #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] shifted,
   output logic [DATA_W-1:0] acc_new,
   output logic              cflag,
   output logic              nflag,
   output logic              zflag
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("rmw_shx_alu: DATA_W must be at least 2");
      end
   endgenerate

   always_comb begin
      shifted = {1'b0, old_val[DATA_W-1:1]};
      acc_new = acc ^ shifted;
      cflag   = old_val[0];
      nflag   = acc_new[DATA_W-1];
      zflag   = (acc_new == '0);
   end

endmodule

// File: rtl/rmw_shx_seq.sv
module rmw_shx_seq
   import rmw_shx_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int ADDR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  amode_t            mode_in,
   input  logic              legal,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] y_in,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] cur_old,
   output logic [DATA_W-1:0] cur_acc,
   input  logic [DATA_W-1:0] alu_shifted,
   input  logic [DATA_W-1:0] alu_acc,
   input  logic              alu_c,
   input  logic              alu_n,
   input  logic              alu_z,
   output logic              done,
   output logic [DATA_W-1:0] a_out,
   output logic              c_out,
   output logic              n_out,
   output logic              z_out,
   output logic              bad_op
);

   localparam logic [DATA_W-1:0] PAGE0 = '0;

   step_t             step_q;
   amode_t            mode_q;
   logic [DATA_W-1:0] ptr_q, data_q, a_q, x_q, y_q;
   logic [ADDR_W-1:0] ea_q, pc_q;
   logic [DATA_W-1:0] idx, fix_lo;

   assign idx     = (mode_q == AM_ABSY || mode_q == AM_IZY) ? y_q : x_q;
   assign fix_lo  = ea_q[DATA_W-1:0] + idx;
   assign cur_old = data_q;
   assign cur_acc = a_q;

   // bus drive for the current step
   always_comb begin
      bus_we    = 1'b0;
      bus_wdata = data_q;
      bus_addr  = ea_q;
      case (step_q)
         ST_IDLE:                bus_addr = pc;
         ST_OPR1:                bus_addr = pc_q + ADDR_W'(1);
         ST_OPR2:                bus_addr = pc_q + ADDR_W'(2);
         ST_ZDUM, ST_PLO, ST_PHI: bus_addr = {PAGE0, ptr_q};
         ST_FIX:                 bus_addr = {ea_q[ADDR_W-1:DATA_W], fix_lo};
         ST_WOLD:                bus_we = 1'b1;
         ST_WNEW: begin
            bus_we    = 1'b1;
            bus_wdata = alu_shifted;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= ST_IDLE;
         mode_q <= AM_ZP;
         ptr_q  <= '0;
         data_q <= '0;
         a_q    <= '0;
         x_q    <= '0;
         y_q    <= '0;
         ea_q   <= '0;
         pc_q   <= '0;
         done   <= 1'b0;
         bad_op <= 1'b0;
         a_out  <= '0;
         c_out  <= 1'b0;
         n_out  <= 1'b0;
         z_out  <= 1'b0;
      end else begin
         done   <= 1'b0;
         bad_op <= 1'b0;
         case (step_q)
            ST_IDLE: if (start) begin
               if (legal) begin
                  mode_q <= mode_in;
                  pc_q   <= pc;
                  a_q    <= a_in;
                  x_q    <= x_in;
                  y_q    <= y_in;
                  step_q <= ST_OPR1;
               end else begin
                  bad_op <= 1'b1;
               end
            end
            ST_OPR1: begin
               ptr_q <= bus_rdata;
               ea_q  <= {PAGE0, bus_rdata};
               case (mode_q)
                  AM_ZP:          step_q <= ST_READ;
                  AM_ZPX, AM_IZX: step_q <= ST_ZDUM;
                  AM_IZY:         step_q <= ST_PLO;
                  default:        step_q <= ST_OPR2;
               endcase
            end
            ST_OPR2: begin
               ea_q[ADDR_W-1:DATA_W] <= bus_rdata;
               step_q <= (mode_q == AM_ABS) ? ST_READ : ST_FIX;
            end
            ST_ZDUM: begin
               ptr_q  <= ptr_q + x_q;
               ea_q   <= {PAGE0, DATA_W'(ptr_q + x_q)};
               step_q <= (mode_q == AM_ZPX) ? ST_READ : ST_PLO;
            end
            ST_PLO: begin
               ea_q[DATA_W-1:0] <= bus_rdata;
               ptr_q  <= ptr_q + DATA_W'(1);
               step_q <= ST_PHI;
            end
            ST_PHI: begin
               ea_q[ADDR_W-1:DATA_W] <= bus_rdata;
               step_q <= (mode_q == AM_IZX) ? ST_READ : ST_FIX;
            end
            ST_FIX: begin
               ea_q   <= ea_q + {PAGE0, idx};
               step_q <= ST_READ;
            end
            ST_READ: begin
               data_q <= bus_rdata;
               step_q <= ST_WOLD;
            end
            ST_WOLD: step_q <= ST_WNEW;
            ST_WNEW: begin
               a_out  <= alu_acc;
               c_out  <= alu_c;
               n_out  <= alu_n;
               z_out  <= alu_z;
               done   <= 1'b1;
               step_q <= ST_IDLE;
            end
            default: step_q <= ST_IDLE;
         endcase
      end
   end

   p_wold_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_WOLD) |-> (bus_we && bus_wdata == $past(bus_rdata)
                               && bus_addr == $past(bus_addr)));

   p_wnew_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_WNEW) |-> (bus_we && bus_addr == $past(bus_addr)
                               && bus_wdata == ($past(bus_wdata) >> 1)));

   p_acc_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (a_out == ($past(a_q) ^ $past(bus_wdata))
                && c_out == $past(data_q[0])));

   p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (n_out == a_out[DATA_W-1] && z_out == (a_out == '0)));

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_bad_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |-> ($past(start) && step_q == ST_IDLE && !bus_we && !done));

   p_page_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_ZDUM || step_q == ST_PLO || step_q == ST_PHI)
      |-> (bus_addr[ADDR_W-1:DATA_W] == '0));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_IDLE) |-> !bus_we);

endmodule

// File: rtl/rmw_shx_unit.sv
module rmw_shx_unit
   import rmw_shx_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int ADDR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] y_in,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output logic [DATA_W-1:0] a_out,
   output logic              c_out,
   output logic              n_out,
   output logic              z_out,
   output logic              bad_op
);

   generate
      if (DATA_W < 2) begin : g_width_check
         $error("rmw_shx_unit: DATA_W must be at least 2");
      end
   endgenerate

   amode_t            mode;
   logic              legal;
   logic [DATA_W-1:0] cur_old, cur_acc, alu_shifted, alu_acc;
   logic              alu_c, alu_n, alu_z;

   rmw_shx_decode u_decode (
      .opcode (opcode),
      .mode   (mode),
      .legal  (legal)
   );

   rmw_shx_alu #(.DATA_W(DATA_W)) u_alu (
      .old_val (cur_old),
      .acc     (cur_acc),
      .shifted (alu_shifted),
      .acc_new (alu_acc),
      .cflag   (alu_c),
      .nflag   (alu_n),
      .zflag   (alu_z)
   );

   rmw_shx_seq #(.DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mode_in     (mode),
      .legal       (legal),
      .pc          (pc),
      .a_in        (a_in),
      .x_in        (x_in),
      .y_in        (y_in),
      .bus_addr    (bus_addr),
      .bus_we      (bus_we),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .cur_old     (cur_old),
      .cur_acc     (cur_acc),
      .alu_shifted (alu_shifted),
      .alu_acc     (alu_acc),
      .alu_c       (alu_c),
      .alu_n       (alu_n),
      .alu_z       (alu_z),
      .done        (done),
      .a_out       (a_out),
      .c_out       (c_out),
      .n_out       (n_out),
      .z_out       (z_out),
      .bad_op      (bad_op)
   );

endmodule

// File: tb/rmw_shx_unit_bench.sv
module rmw_shx_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = '0, a_in = '0, x_in = '0, y_in = '0;
   logic [15:0] pc = '0;
   logic [15:0] bus_addr;
   logic        bus_we;
   logic [7:0]  bus_wdata, bus_rdata;
   logic        done, c_out, n_out, z_out, bad_op;
   logic [7:0]  a_out;

   logic [7:0]  mem [0:2047];

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   rmw_shx_unit u_rmw_shx_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc(pc),
      .a_in(a_in), .x_in(x_in), .y_in(y_in),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .done(done), .a_out(a_out), .c_out(c_out),
      .n_out(n_out), .z_out(z_out), .bad_op(bad_op)
   );

   assign bus_rdata = mem[bus_addr[10:0]];
   always @(posedge clk) if (bus_we) mem[bus_addr[10:0]] <= bus_wdata;

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rd(input logic [15:0] a);
      return mem[a[10:0]];
   endfunction

   logic [15:0] exp_a [0:15];
   bit          exp_w [0:15];
   int          exp_n;
   logic [15:0] exp_ea;
   logic [15:0] tr_a [0:15];
   bit          tr_w [0:15];
   logic [7:0]  tr_d [0:15];

   task automatic push(input logic [15:0] a, input bit w);
      exp_a[exp_n] = a;
      exp_w[exp_n] = w;
      exp_n++;
   endtask

   // model of the bus sequence per mode (R3, R4, R5, R6)
   task automatic expect_seq(input logic [7:0] opc, input logic [15:0] p,
                             input logic [7:0] x, input logic [7:0] y);
      logic [7:0] o1, o2, t, lo, hi;
      o1 = rd(p + 16'd1);
      o2 = rd(p + 16'd2);
      exp_n = 0;
      push(p, 1'b0);
      push(p + 16'd1, 1'b0);
      case (opc)
         8'h47: exp_ea = {8'h00, o1};
         8'h57: begin
            push({8'h00, o1}, 1'b0);
            t = o1 + x;
            exp_ea = {8'h00, t};
         end
         8'h4F: begin
            push(p + 16'd2, 1'b0);
            exp_ea = {o2, o1};
         end
         8'h5F, 8'h5B: begin
            push(p + 16'd2, 1'b0);
            t = o1 + ((opc == 8'h5B) ? y : x);
            push({o2, t}, 1'b0);
            exp_ea = {o2, o1} + {8'h00, (opc == 8'h5B) ? y : x};
         end
         8'h43: begin
            push({8'h00, o1}, 1'b0);
            t = o1 + x;
            push({8'h00, t}, 1'b0);
            lo = rd({8'h00, t});
            t = t + 8'd1;
            push({8'h00, t}, 1'b0);
            hi = rd({8'h00, t});
            exp_ea = {hi, lo};
         end
         default: begin
            push({8'h00, o1}, 1'b0);
            t = o1 + 8'd1;
            push({8'h00, t}, 1'b0);
            lo = rd({8'h00, o1});
            hi = rd({8'h00, t});
            t = lo + y;
            push({hi, t}, 1'b0);
            exp_ea = {hi, lo} + {8'h00, y};
         end
      endcase
      push(exp_ea, 1'b0);
      push(exp_ea, 1'b1);
      push(exp_ea, 1'b1);
   endtask

   task automatic run_case(input logic [7:0] opc, input logic [15:0] p,
                           input logic [7:0] o1, input logic [7:0] o2,
                           input logic [7:0] a, input logic [7:0] x,
                           input logic [7:0] y, input bit set_old,
                           input logic [7:0] old_set, input bit spam,
                           input string req);
      logic [7:0] old, sh, an;
      int cyc, mism;
      bit saw_bad;
      mem[p[10:0]] = opc;
      mem[(p + 16'd1) & 16'h07FF] = o1;
      mem[(p + 16'd2) & 16'h07FF] = o2;
      expect_seq(opc, p, x, y);
      if (set_old) mem[exp_ea[10:0]] = old_set;
      old = rd(exp_ea);
      sh = {1'b0, old[7:1]};
      an = a ^ sh;
      @(negedge clk);
      start = 1'b1; opcode = opc; pc = p; a_in = a; x_in = x; y_in = y;
      cyc = -1;
      saw_bad = 1'b0;
      for (int k = 0; k < 16; k++) begin
         #8;
         if (bad_op) saw_bad = 1'b1;
         if (done) begin
            cyc = k;
            break;
         end
         tr_a[k] = bus_addr;
         tr_w[k] = bus_we;
         tr_d[k] = bus_wdata;
         @(negedge clk);
         if (spam && k < 2) begin
            start = 1'b1;
            opcode = 8'h02;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      check(cyc == exp_n, {req, " R2"}, "cycle count", cyc, exp_n);
      mism = 0;
      for (int i = 0; i < exp_n; i++)
         if (tr_a[i] !== exp_a[i] || tr_w[i] != exp_w[i]) mism++;
      check(mism == 0, {req, " R3"}, "bus address/write sequence mismatches", mism, 0);
      check(tr_d[exp_n-2] == old, "R6", "unchanged write-back data", tr_d[exp_n-2], old);
      check(tr_d[exp_n-1] == sh, "R7", "shifted write data", tr_d[exp_n-1], sh);
      check(rd(exp_ea) == sh, "R7", "final memory byte", rd(exp_ea), sh);
      check(a_out == an, "R8", "accumulator", a_out, an);
      check(c_out == old[0], "R8", "carry", c_out, old[0]);
      check(n_out == an[7], "R9", "negative flag", n_out, an[7]);
      check(z_out == (an == 8'h00), "R9", "zero flag", z_out, an == 8'h00);
      check(!saw_bad, spam ? "R10" : "R1", "bad_op during legal instruction", saw_bad, 0);
   endtask

   task automatic run_bad(input logic [7:0] opc);
      @(negedge clk);
      start = 1'b1; opcode = opc; pc = 16'h0200;
      #8;
      check(!bus_we, "R1", "write in rejected fetch cycle", bus_we, 0);
      @(negedge clk);
      start = 1'b0;
      #8;
      check(bad_op && !done && !bus_we, "R1", "bad_op pulse after unsupported opcode",
            {bad_op, done, bus_we}, 3'b100);
      @(negedge clk);
      #8;
      check(!bad_op && !done && !bus_we, "R1", "bad_op is one cycle and unit idle",
            {bad_op, done, bus_we}, 3'b000);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 2048; i++) mem[i] = 8'($urandom);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #8;
      check(!done && !bad_op && !bus_we, "R11", "outputs in reset",
            {done, bad_op, bus_we}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #8;
      check(!done && !bad_op && !bus_we, "R11", "outputs after reset",
            {done, bad_op, bus_we}, 0);

      // directed corner cases
      run_case(8'h47, 16'h0200, 8'h10, 8'h00, 8'h55, 8'h00, 8'h00, 1'b1, 8'hC3, 1'b0, "R3 zp");
      run_case(8'h47, 16'h0200, 8'h20, 8'h00, 8'h55, 8'h00, 8'h00, 1'b1, 8'hAA, 1'b0, "R9 zero result");
      run_case(8'h47, 16'h0200, 8'h21, 8'h00, 8'h80, 8'h00, 8'h00, 1'b1, 8'h01, 1'b0, "R9 negative");
      run_case(8'h57, 16'h0200, 8'hF0, 8'h00, 8'h3C, 8'h20, 8'h00, 1'b1, 8'hFF, 1'b0, "R4 zpx wrap");
      run_case(8'h4F, 16'h0200, 8'h34, 8'h03, 8'h01, 8'h00, 8'h00, 1'b1, 8'h81, 1'b0, "R3 abs");
      run_case(8'h5F, 16'h0200, 8'hF0, 8'h05, 8'h0F, 8'h20, 8'h00, 1'b1, 8'h7E, 1'b0, "R5 absx cross");
      run_case(8'h5B, 16'h0200, 8'h10, 8'h06, 8'hF0, 8'h00, 8'h05, 1'b1, 8'h42, 1'b0, "R5 absy");
      mem[8'hFF] = 8'h80; mem[8'h00] = 8'h07;
      run_case(8'h43, 16'h0200, 8'hFE, 8'h00, 8'h11, 8'h01, 8'h00, 1'b1, 8'h33, 1'b0, "R4 izx wrap");
      mem[8'hFF] = 8'h40; mem[8'h00] = 8'h06;
      run_case(8'h53, 16'h0200, 8'hFF, 8'h00, 8'h22, 8'h00, 8'h10, 1'b1, 8'h9A, 1'b0, "R4 izy wrap");
      mem[8'h30] = 8'hF8; mem[8'h31] = 8'h05;
      run_case(8'h53, 16'h0200, 8'h30, 8'h00, 8'h66, 8'h00, 8'h10, 1'b1, 8'h5B, 1'b0, "R5 izy cross");
      run_case(8'h47, 16'h0200, 8'h44, 8'h00, 8'h12, 8'h00, 8'h00, 1'b1, 8'h0F, 1'b1, "R10 start while busy");
      run_bad(8'h4E);
      run_bad(8'h00);
      run_bad(8'hFF);

      // constrained random instructions
      for (int n = 0; n < 200; n++) begin
         logic [7:0]  opc, o1, o2, x, y, t;
         logic [15:0] p;
         case ($urandom % 7)
            0: opc = 8'h47;
            1: opc = 8'h57;
            2: opc = 8'h4F;
            3: opc = 8'h5F;
            4: opc = 8'h5B;
            5: opc = 8'h43;
            default: opc = 8'h53;
         endcase
         p  = 16'h0400 + 16'($urandom % 16'h0200);
         o1 = 8'($urandom);
         o2 = 8'(1 + $urandom % 6);
         x  = 8'($urandom);
         y  = 8'($urandom);
         if (opc == 8'h43) begin
            t = o1 + x;
            mem[t] = 8'($urandom);
            t = t + 8'd1;
            mem[t] = 8'(1 + $urandom % 6);
         end else if (opc == 8'h53) begin
            mem[o1] = 8'($urandom);
            t = o1 + 8'd1;
            mem[t] = 8'(1 + $urandom % 6);
         end
         run_case(opc, p, o1, o2, 8'($urandom), x, y, 1'b0, 8'h00, 1'b0, "R2 random");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule